// File: doc/BRIEF.md
# Segment Descriptor Load Unit

This unit fills a small cache of five segment registers (code, data, stack and two extra) from descriptor tables held in memory. A load request carries a 16-bit selector and the id of the register to fill. A selector bit chooses between the two tables that can be active, a global one and a local one. The unit adds the scaled index to that table's base register, fetches the 8-byte descriptor as two 32-bit reads over a valid/ready read port, and writes base, limit, access bits and privilege level into the chosen register. Address translation then uses the cached copy and does not read the table again.

The two table registers each hold a base and a byte limit. Software writes them through a dedicated port, and a write is accepted only while the current privilege level is 0. Loading the code register sets the current privilege level to the privilege level of the loaded descriptor. Any cached register can be read back through a registered read port.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector layout: bits [1:0] are the requested privilege level and are ignored here, bit 2 set selects the local table and clear selects the global table, and bits [15:3] are the index. The first read address is the selected table base plus index×8.
- R2: A descriptor is fetched as exactly two reads, the low word at the computed address and then the high word at that address plus 4. `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen.
- R3: A load whose last descriptor byte (index×8+7) is above the selected table's limit ends with `done` and `fault` high together, issues no memory read and leaves every cache entry unchanged.
- R4: A table register write updates the base and limit only when the current privilege level is 0. Otherwise it raises `fault` for one cycle, and the table register stays unchanged.
- R5: Descriptor layout: the low word is the segment base, high word bits [19:0] are the limit, bits [27:20] are the access bits and bits [29:28] are the descriptor privilege level. A completed load stores exactly these fields in the target entry.
- R6: A completed load into register id 0 (code) sets `cpl` to the descriptor privilege level. Loads into ids 1 to 4 leave `cpl` unchanged.
- R7: `req_ready` is low from acceptance until the load finishes. A request made while busy is ignored and changes no entry.
- R8: Each accepted request produces exactly one single-cycle `done` pulse, and `req_ready` is low while `done` is high.
- R9: After reset `cpl` is 0, both table bases and limits are 0, all five entries read as zero, `req_ready` is high, and `done` and `fault` are low.
- R10: `rd_base`, `rd_limit`, `rd_access` and `rd_dpl` show the entry selected by `rd_seg` one clock after `rd_seg` is applied.
- R11: A request whose target id is 5, 6 or 7 ends with `done` and `fault` high and issues no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_sel | input | 16 | Selector of the descriptor to load |
| req_seg | input | 3 | Target register id (0 code, 1 data, 2 stack, 3 and 4 extra) |
| tbl_wr | input | 1 | Table register write strobe |
| tbl_wr_local | input | 1 | 1 writes the local table register, 0 the global |
| tbl_wr_base | input | 32 | New table base |
| tbl_wr_limit | input | 16 | New table limit (last valid byte offset) |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle load completion pulse |
| fault | output | 1 | Load fault (with done) or rejected table write (alone) |
| cpl | output | 2 | Current privilege level |
| rd_seg | input | 3 | Register id to read back |
| rd_base | output | 32 | Read-back base |
| rd_limit | output | 20 | Read-back limit |
| rd_access | output | 8 | Read-back access bits |
| rd_dpl | output | 2 | Read-back descriptor privilege level |

## Verification
The bound checker watches the read-port handshake on every cycle. It checks that a pending read holds its address, that `req_ready` stays low during a fetch, that `done` is a lone pulse, that a load fault never coincides with an outstanding read, that `cpl` moves only on a completion, and that reset brings back the idle state. Only the bench's scenarios can show the correct table choice and address arithmetic, the field placement in the cache, the limit boundary at index×8+7, the rejection of table writes at a nonzero privilege level, and that a request made while busy leaves every entry untouched. The bench sweeps every index around both table limits while varying memory stalls and latency.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int DATA_W   = 32;
  localparam int DLIM_W   = 20;
  localparam int DACC_W   = 8;
  localparam int DPL_W    = 2;
  localparam int DLIM_LSB = 0;
  localparam int DACC_LSB = 20;
  localparam int DPL_LSB  = 28;

  typedef struct packed {
    logic [DATA_W-1:0] base;
    logic [DLIM_W-1:0] limit;
    logic [DACC_W-1:0] access;
    logic [DPL_W-1:0]  dpl;
  } seg_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_WT_LO,
    ST_RD_HI,
    ST_WT_HI,
    ST_FIN
  } fetch_st_t;

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs #(
  parameter int TLIM_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_local,
  input  logic [seg_pkg::DATA_W-1:0] wr_base,
  input  logic [TLIM_W-1:0]          wr_limit,
  input  logic [1:0]                 cur_pl,
  output logic [seg_pkg::DATA_W-1:0] glb_base,
  output logic [TLIM_W-1:0]          glb_limit,
  output logic [seg_pkg::DATA_W-1:0] loc_base,
  output logic [TLIM_W-1:0]          loc_limit,
  output logic                       wr_fault
);
  localparam int NTBL = 2;

  logic [seg_pkg::DATA_W-1:0] base_q  [NTBL];
  logic [TLIM_W-1:0]          limit_q [NTBL];

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[t]  <= '0;
        limit_q[t] <= '0;
      end else if (wr_en && (cur_pl == 2'd0) && (wr_local == (t == 1))) begin
        base_q[t]  <= wr_base;
        limit_q[t] <= wr_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_fault <= 1'b0;
    else     wr_fault <= wr_en && (cur_pl != 2'd0);
  end

  assign glb_base  = base_q[0];
  assign glb_limit = limit_q[0];
  assign loc_base  = base_q[1];
  assign loc_limit = limit_q[1];
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch #(
  parameter int NUM_SEG = 5,
  parameter int SEL_W   = 16,
  parameter int TLIM_W  = 16,
  parameter int CODE_ID = 0,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int IDX_W  = SEL_W - 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [SEL_W-1:0]           req_sel,
  input  logic [SEG_W-1:0]           req_seg,
  input  logic [seg_pkg::DATA_W-1:0] glb_base,
  input  logic [TLIM_W-1:0]          glb_limit,
  input  logic [seg_pkg::DATA_W-1:0] loc_base,
  input  logic [TLIM_W-1:0]          loc_limit,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [seg_pkg::DATA_W-1:0] mem_rd_addr,
  input  logic                       mem_rsp_valid,
  input  logic [seg_pkg::DATA_W-1:0] mem_rsp_data,
  output logic                       ent_we,
  output logic [SEG_W-1:0]           ent_idx,
  output seg_pkg::seg_entry_t        ent_data,
  output logic                       done,
  output logic                       ld_fault,
  output logic [1:0]                 cpl
);
  import seg_pkg::*;

  localparam int PAD_W = DATA_W - SEL_W;
  localparam int LPAD_W = DATA_W - TLIM_W;

  fetch_st_t          st_q;
  logic [DATA_W-1:0]  lo_q;
  logic [IDX_W-1:0]   idx;
  logic               use_loc;
  logic [DATA_W-1:0]  tbl_base;
  logic [TLIM_W-1:0]  tbl_limit;
  logic [DATA_W-1:0]  last_byte;
  logic [DATA_W-1:0]  desc_addr;
  logic               over_lim;
  logic               bad_seg;

  assign idx       = req_sel[SEL_W-1:3];
  assign use_loc   = req_sel[2];
  assign tbl_base  = use_loc ? loc_base  : glb_base;
  assign tbl_limit = use_loc ? loc_limit : glb_limit;
  assign last_byte = {{PAD_W{1'b0}}, idx, 3'b111};
  assign desc_addr = tbl_base + {{PAD_W{1'b0}}, idx, 3'b000};
  assign over_lim  = last_byte > {{LPAD_W{1'b0}}, tbl_limit};
  assign bad_seg   = 32'(req_seg) >= NUM_SEG;
  assign req_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      lo_q         <= '0;
      ent_we       <= 1'b0;
      ent_idx      <= '0;
      ent_data     <= '0;
      done         <= 1'b0;
      ld_fault     <= 1'b0;
      cpl          <= 2'd0;
    end else begin
      done     <= 1'b0;
      ld_fault <= 1'b0;
      ent_we   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (bad_seg || over_lim) begin
              done     <= 1'b1;
              ld_fault <= 1'b1;
              st_q     <= ST_FIN;
            end else begin
              mem_rd_addr  <= desc_addr;
              mem_rd_valid <= 1'b1;
              ent_idx      <= req_seg;
              st_q         <= ST_RD_LO;
            end
          end
        end
        ST_RD_LO: begin
          if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            st_q         <= ST_WT_LO;
          end
        end
        ST_WT_LO: begin
          if (mem_rsp_valid) begin
            lo_q         <= mem_rsp_data;
            mem_rd_addr  <= mem_rd_addr + 32'd4;
            mem_rd_valid <= 1'b1;
            st_q         <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            st_q         <= ST_WT_HI;
          end
        end
        ST_WT_HI: begin
          if (mem_rsp_valid) begin
            ent_we          <= 1'b1;
            ent_data.base   <= lo_q;
            ent_data.limit  <= mem_rsp_data[DLIM_LSB +: DLIM_W];
            ent_data.access <= mem_rsp_data[DACC_LSB +: DACC_W];
            ent_data.dpl    <= mem_rsp_data[DPL_LSB +: DPL_W];
            if (32'(ent_idx) == CODE_ID) cpl <= mem_rsp_data[DPL_LSB +: DPL_W];
            done            <= 1'b1;
            st_q            <= ST_FIN;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache #(
  parameter int NUM_SEG = 5,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SEG_W-1:0]    widx,
  input  seg_pkg::seg_entry_t wdata,
  input  logic [SEG_W-1:0]    ridx,
  output seg_pkg::seg_entry_t rdata
);
  import seg_pkg::*;

  seg_entry_t ent [NUM_SEG];
  seg_entry_t rsel;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                              ent[g] <= '0;
      else if (we && (32'(widx) == g))      ent[g] <= wdata;
    end
  end

  always_comb begin
    rsel = '0;
    for (int g = 0; g < NUM_SEG; g++) begin
      if (32'(ridx) == g) rsel = ent[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rsel;
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader #(
  parameter int NUM_SEG = 5,
  parameter int SEL_W   = 16,
  parameter int TLIM_W  = 16,
  parameter int CODE_ID = 0,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              tbl_wr,
  input  logic              tbl_wr_local,
  input  logic [31:0]       tbl_wr_base,
  input  logic [TLIM_W-1:0] tbl_wr_limit,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        cpl,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic [31:0]       rd_base,
  output logic [19:0]       rd_limit,
  output logic [7:0]        rd_access,
  output logic [1:0]        rd_dpl
);
  import seg_pkg::*;

  logic [DATA_W-1:0] glb_base, loc_base;
  logic [TLIM_W-1:0] glb_limit, loc_limit;
  logic              wr_fault, ld_fault;
  logic              ent_we;
  logic [SEG_W-1:0]  ent_idx;
  seg_entry_t        ent_data;
  seg_entry_t        rd_ent;

  seg_tbl_regs #(.TLIM_W(TLIM_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr), .wr_local(tbl_wr_local),
    .wr_base(tbl_wr_base), .wr_limit(tbl_wr_limit),
    .cur_pl(cpl),
    .glb_base(glb_base), .glb_limit(glb_limit),
    .loc_base(loc_base), .loc_limit(loc_limit),
    .wr_fault(wr_fault)
  );

  seg_fetch #(
    .NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .TLIM_W(TLIM_W), .CODE_ID(CODE_ID)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_seg(req_seg),
    .glb_base(glb_base), .glb_limit(glb_limit),
    .loc_base(loc_base), .loc_limit(loc_limit),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_data(ent_data),
    .done(done), .ld_fault(ld_fault), .cpl(cpl)
  );

  seg_cache #(.NUM_SEG(NUM_SEG)) u_cache (
    .clk(clk), .rst(rst),
    .we(ent_we), .widx(ent_idx), .wdata(ent_data),
    .ridx(rd_seg), .rdata(rd_ent)
  );

  assign fault     = wr_fault | ld_fault;
  assign rd_base   = rd_ent.base;
  assign rd_limit  = rd_ent.limit;
  assign rd_access = rd_ent.access;
  assign rd_dpl    = rd_ent.dpl;
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  cpl
);
  // R9: reset returns the idle outputs
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !fault && cpl == 2'd0));

  // R2: a pending read holds valid and address
  assert_hold_read_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R7: no new request accepted while a fetch is outstanding
  assert_busy_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R8: done is a single-cycle pulse and the unit is not ready with it
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  // R3: a load fault leaves no read outstanding
  assert_fault_noread_R3: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !mem_rd_valid);

  // R6: privilege level only moves on a completion
  assert_cpl_on_done_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cpl) |-> done);
endmodule

bind seg_desc_loader seg_desc_loader_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .done(done), .fault(fault), .cpl(cpl)
);

// File: tb/seg_desc_loader_bench.sv
`timescale 1ns/1ps
module seg_desc_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [2:0]  req_seg = '0;
  logic        tbl_wr = 1'b0;
  logic        tbl_wr_local = 1'b0;
  logic [31:0] tbl_wr_base = '0;
  logic [15:0] tbl_wr_limit = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [1:0]  cpl;
  logic [2:0]  rd_seg = '0;
  logic [31:0] rd_base;
  logic [19:0] rd_limit;
  logic [7:0]  rd_access;
  logic [1:0]  rd_dpl;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] e_base [5];
  logic [19:0] e_lim  [5];
  logic [7:0]  e_acc  [5];
  logic [1:0]  e_dpl  [5];
  logic [1:0]  e_cpl;
  logic [31:0] t_base [2];
  logic [15:0] t_lim  [2];

  always #2.5 clk = ~clk;

  seg_desc_loader u_seg_desc_loader (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_seg(req_seg),
    .tbl_wr(tbl_wr), .tbl_wr_local(tbl_wr_local),
    .tbl_wr_base(tbl_wr_base), .tbl_wr_limit(tbl_wr_limit),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .cpl(cpl),
    .rd_seg(rd_seg), .rd_base(rd_base), .rd_limit(rd_limit),
    .rd_access(rd_access), .rd_dpl(rd_dpl)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_check(input logic [2:0] s);
    @(negedge clk);
    rd_seg = s;
    @(negedge clk);
    chk({rd_base, rd_limit, rd_access, rd_dpl} == {e_base[s], e_lim[s], e_acc[s], e_dpl[s]},
        "R5 R10 entry", {2'b0, rd_base, rd_limit, rd_access, rd_dpl},
        {2'b0, e_base[s], e_lim[s], e_acc[s], e_dpl[s]});
  endtask

  task automatic tbl_write(input bit loc, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_wr_local = loc; tbl_wr_base = b; tbl_wr_limit = l;
    @(negedge clk);
    chk(fault == (e_cpl != 2'd0), "R4 write fault", {63'b0, fault}, {63'b0, e_cpl != 2'd0});
    tbl_wr = 1'b0;
    if (e_cpl == 2'd0) begin
      t_base[loc] = b;
      t_lim[loc]  = l;
    end
  endtask

  task automatic run_load(input logic [2:0] seg, input logic [15:0] sel,
                          input int stall, input int lat, input bit intrude);
    logic        tsel;
    logic [12:0] idx;
    logic [15:0] last;
    logic [31:0] a0, hi, cur;
    logic [31:0] ad [2];
    bit          expf, sawf;
    int          phase, sc, wc, nrd, ndone;
    tsel = sel[2];
    idx  = sel[15:3];
    last = {idx, 3'b111};
    expf = (seg > 3'd4) || (last > t_lim[tsel]);
    a0   = t_base[tsel] + {16'b0, idx, 3'b000};
    phase = 0; sc = 0; wc = 0; nrd = 0; ndone = 0; sawf = 0;
    ad[0] = '0; ad[1] = '0; cur = '0;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_seg = seg;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude && c == 4) begin
        req_valid = 1'b1;
        req_seg = (seg == 3'd4) ? 3'd1 : seg + 3'd1;
      end
      if (done) begin
        ndone++;
        if (fault) sawf = 1;
      end
      mem_rsp_valid = 1'b0;
      case (phase)
        0: if (mem_rd_valid) begin
             chk(!req_ready, "R7 busy ready", {63'b0, req_ready}, 64'd0);
             if (sc < stall) begin
               sc++;
               mem_rd_ready = 1'b0;
             end else begin
               mem_rd_ready = 1'b1;
               if (nrd < 2) ad[nrd] = mem_rd_addr;
               nrd++;
               cur = mem_rd_addr;
               phase = 1; wc = 0;
             end
           end
        1: begin
             mem_rd_ready = 1'b0;
             if (wc >= lat) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data = mem_word(cur);
               phase = 2;
             end else wc++;
           end
        default: begin phase = 0; sc = 0; end
      endcase
    end
    chk(ndone == 1, "R8 done count", 64'(ndone), 64'd1);
    chk(sawf == expf, (seg > 3'd4) ? "R11 fault" : "R3 fault", {63'b0, sawf}, {63'b0, expf});
    if (expf) begin
      chk(nrd == 0, "R3 no read", 64'(nrd), 64'd0);
    end else begin
      chk(nrd == 2, "R2 read count", 64'(nrd), 64'd2);
      chk(ad[0] == a0, "R1 low addr", {32'b0, ad[0]}, {32'b0, a0});
      chk(ad[1] == a0 + 32'd4, "R2 high addr", {32'b0, ad[1]}, {32'b0, a0 + 32'd4});
      hi = mem_word(a0 + 32'd4);
      e_base[seg] = mem_word(a0);
      e_lim[seg]  = hi[19:0];
      e_acc[seg]  = hi[27:20];
      e_dpl[seg]  = hi[29:28];
      if (seg == 3'd0) e_cpl = hi[29:28];
    end
    @(negedge clk);
    chk(cpl == e_cpl, "R6 cpl", {62'b0, cpl}, {62'b0, e_cpl});
    for (int s = 0; s < 5; s++) read_check(3'(s));
  endtask

  function automatic int find_dpl(input logic [31:0] base, input bit want_zero);
    logic [31:0] hw;
    for (int j = 0; j < 32; j++) begin
      hw = mem_word(base + 32'(j * 8) + 32'd4);
      if ((hw[29:28] == 2'd0) == want_zero) return j;
    end
    return -1;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int j;
    for (int s = 0; s < 5; s++) begin
      e_base[s] = '0; e_lim[s] = '0; e_acc[s] = '0; e_dpl[s] = '0;
    end
    e_cpl = 2'd0;
    t_base[0] = '0; t_base[1] = '0; t_lim[0] = '0; t_lim[1] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9 ready", {63'b0, req_ready}, 64'd1);
    chk(!done && !fault, "R9 done fault", {62'b0, done, fault}, 64'd0);
    chk(cpl == 2'd0, "R9 cpl", {62'b0, cpl}, 64'd0);
    for (int s = 0; s < 5; s++) read_check(3'(s));
    // R9: zero table limits make index 0 fault
    run_load(3'd1, 16'h0000, 0, 0, 0);

    tbl_write(1'b0, 32'h0000_1000, 16'h00FF);
    tbl_write(1'b1, 32'h0002_0000, 16'h003F);

    // R1 R3: sweep the global table across its limit
    for (int i = 0; i < 34; i++)
      run_load(3'(i % 5), {13'(i), 1'b0, 2'(i % 4)}, i % 3, i % 4, 0);
    // R1 R3: sweep the local table across its limit
    for (int i = 0; i < 10; i++)
      run_load(3'((i + 2) % 5), {13'(i), 1'b1, 2'(3 - i % 4)}, (i + 1) % 3, i % 3, 0);

    // R11: target ids beyond the five registers
    for (int s = 5; s < 8; s++) run_load(3'(s), {13'd1, 1'b0, 2'd0}, 0, 0, 0);

    // R7: request during a fetch is ignored
    run_load(3'd2, {13'd3, 1'b0, 2'd0}, 1, 2, 1);

    // R4 R6: raise cpl via a code load, then try a table write
    j = find_dpl(t_base[0], 0);
    if (j >= 0) begin
      run_load(3'd0, {13'(j), 1'b0, 2'd0}, 0, 1, 0);
      tbl_write(1'b0, 32'h0005_0000, 16'hFFFF);
      run_load(3'd1, {13'd40, 1'b0, 2'd0}, 0, 0, 0);
      run_load(3'd3, {13'd2, 1'b0, 2'd0}, 2, 0, 0);
    end
    j = find_dpl(t_base[0], 1);
    if (j >= 0) begin
      run_load(3'd0, {13'(j), 1'b0, 2'd0}, 0, 0, 0);
      tbl_write(1'b0, 32'h0005_0000, 16'hFFFF);
      run_load(3'd4, {13'd40, 1'b0, 2'd1}, 1, 1, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule